// File: doc/BRIEF.md
# Fourteen-Tick Oversampled UART

This block is a serial port controller that sits on a simple word-addressed register bus. Software writes bytes into a 64-entry transmit queue and the block sends them as 8N1 frames: start bit low, eight data bits with the least significant bit first, then a high stop bit. Incoming frames on the receive line are sampled and stored with per-character break and error status in a 64-entry receive queue. Every bit lasts 14 ticks of a rate strobe. The strobe fires once every RATE+1 clocks, so one bit lasts 14×(RATE+1) clocks.

Coded fields in the control word set the receive and transmit trigger levels, the receive timeout and the RTS threshold. Sticky interrupt flags are cleared by writing 1 to them. They are combined with three enable bits into a single interrupt line. An optional CTS input holds back the start of new frames. An optional RTS output follows the receive fill level.

Top module: `uart14_top`

## Requirements
- R1: The transmit line idles high. Each frame is a low start bit, 8 data bits sent LSB first and a high stop bit. Each bit lasts 14×(RATE+1) clocks, where RATE is the 8-bit value at word 4.
- R2: The word addresses are 0 data port, 1 level, 2 interrupt flags, 3 control and 4 rate. The level word holds the transmit queue count in bits 15:8 and the receive queue count in bits 7:0. A write to word 0 queues a byte for sending.
- R3: A read of word 0 returns the byte in bits 7:0, the empty flag in bit 8, the error flag in bit 9 and the break flag in bit 10, and removes that entry. Bytes come out in arrival order. An empty queue reads 0x100.
- R4: A start bit is accepted only if the line is still low on the 7th tick after the first low tick. A shorter low pulse produces no character.
- R5: A stop bit sampled low sets the entry's error flag and flag bit 3. If the data byte is also zero, the entry's break flag and flag bit 4 are set as well.
- R6: Each queue holds 64 entries. A character that arrives when the receive queue is full is dropped, and flag bit 5 is set.
- R7: Flag bit 1 is set while the receive count is at or above the threshold coded in control bits 4:2. The codes 0 to 5 give 1, 4, 8, 16, 32 and 48. Flag bit 0 is set when a byte moves from the transmit queue to the shifter and leaves the count equal to the threshold coded in bits 1:0, where the codes 0 to 3 give 0, 4, 8 and 16. Bit 6 reads 1 while the transmit count is at or below that threshold.
- R8: Control bits 17:16 set the receive timeout. Code 0 disables it; codes 1, 2 and 3 give 4, 8 and 16 character times, each character time being 140 ticks. The timer restarts on every received character and runs only while the receive queue is not empty. Expiry sets flag bit 2 once.
- R9: Writing 1 to any of flag bits 5:0 clears it. Writing 0 leaves it unchanged.
- R10: The interrupt output is high when flag bit 0 is set with control bit 5, when flag bit 1 or 2 is set with control bit 6, or when any of flag bits 3 to 5 is set with control bit 7.
- R11: When control bit 14 is set, a new frame starts only while the CTS input XOR control bit 15 is 1.
- R12: When control bit 18 is set, the raw RTS value is 1 while the receive count is below the threshold coded in bits 20:19 (8, 16, 32 or 48), and 0 otherwise. When bit 18 is clear the raw value is 1. The RTS output equals the raw value XOR control bit 21.
- R13: Control bit 8 forces the transmit line low from the next clock. Control bits 13:9 hold a sample-offset value that is stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Word address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (a read of word 0 removes an entry) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| rxdIn | input | 1 | Serial receive line |
| txdOut | output | 1 | Serial transmit line |
| ctsIn | input | 1 | Clear-to-send input |
| rtsOut | output | 1 | Request-to-send output |
| irqOut | output | 1 | Interrupt request |

## Verification
A write takes effect at the clock edge that ends the write cycle. Read data is combinational, so the bench samples it in the same low clock phase, and the entry is removed at the next edge. A received character enters the queue about 135 clocks after its start edge: two synchroniser stages, the 7-tick start check and nine 14-tick samples. The bench therefore checks the queue 146 clocks after it begins driving a frame. Timer, trigger and flow-control results are sampled either with margins that fall clearly inside or clearly outside the expected window, or several cycles after their cause. Serial output is sampled at the middle of each bit, counted from the detected start edge.

// File: rtl/uart14_pkg.sv
package uart14_pkg;
  localparam int BIT_TICKS  = 14;
  localparam int FRAME_BITS = 10;

  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_LEVEL = 3'd1;
  localparam logic [2:0] A_FLAGS = 3'd2;
  localparam logic [2:0] A_CTRL  = 3'd3;
  localparam logic [2:0] A_RATE  = 3'd4;

  typedef enum logic [1:0] { RX_IDLE, RX_START, RX_DATA } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       tick;
    logic       rxPop;
    logic       txPush;
    logic [7:0] txByte;
    logic       txGo;
    logic       brk;
  } u14Strobe_t;

  // single-cycle events from datapath to control
  typedef struct packed {
    logic rxPushed;
    logic rxOverrun;
    logic rxFrameErr;
    logic rxBreak;
    logic txPopped;
  } u14Event_t;
endpackage

// File: rtl/uart14_fifo.sv
module uart14_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign dout   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart14_datapath.sv
module uart14_datapath
  import uart14_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  u14Strobe_t    stb,
  input  logic          rxdIn,
  output logic          txdOut,
  output logic [9:0]    rxHead,
  output logic [CW-1:0] rxCount,
  output logic [CW-1:0] txCount,
  output u14Event_t     evt
);
  localparam logic [3:0] LAST_TICK = 4'(BIT_TICKS - 1);
  localparam logic [3:0] MID_TICK  = 4'(BIT_TICKS / 2 - 1);

  // receive side
  logic [1:0] rxSync;
  logic       rxBit;
  rxState_t   rxState;
  logic [3:0] rxTick, rxIdx;
  logic [7:0] rxShift;
  logic       rxPushReq;
  logic [9:0] rxWord;

  assign rxBit = rxSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync    <= 2'b11;
      rxState   <= RX_IDLE;
      rxTick    <= '0;
      rxIdx     <= '0;
      rxShift   <= '0;
      rxPushReq <= 1'b0;
      rxWord    <= '0;
    end else begin
      rxSync    <= {rxSync[0], rxdIn};
      rxPushReq <= 1'b0;
      if (stb.tick) begin
        case (rxState)
          RX_IDLE: if (!rxBit) begin
            rxState <= RX_START;
            rxTick  <= 4'd1;
          end
          RX_START: if (rxTick == MID_TICK) begin
            rxState <= rxBit ? RX_IDLE : RX_DATA;
            rxTick  <= '0;
            rxIdx   <= '0;
          end else rxTick <= rxTick + 1'b1;
          default: if (rxTick == LAST_TICK) begin
            rxTick <= '0;
            if (rxIdx != 4'd8) begin
              rxShift <= {rxBit, rxShift[7:1]};
              rxIdx   <= rxIdx + 1'b1;
            end else begin
              rxPushReq <= 1'b1;
              rxWord    <= {!rxBit && (rxShift == 8'd0), !rxBit, rxShift};
              rxState   <= RX_IDLE;
            end
          end else rxTick <= rxTick + 1'b1;
        endcase
      end
    end
  end

  uart14_fifo #(.W(10), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(rxPushReq), .pop(stb.rxPop),
    .din(rxWord), .dout(rxHead), .count(rxCount)
  );

  // transmit side
  logic [7:0] txHeadByte;
  logic       txLoad, txBusy;
  logic [9:0] txShift;
  logic [3:0] txTick, txBitN;

  assign txLoad = !txBusy && (txCount != '0) && stb.txGo && !stb.brk;

  uart14_fifo #(.W(8), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pop(txLoad),
    .din(stb.txByte), .dout(txHeadByte), .count(txCount)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txShift <= '1;
      txTick  <= '0;
      txBitN  <= '0;
      txdOut  <= 1'b1;
    end else begin
      if (txLoad) begin
        txShift <= {1'b1, txHeadByte, 1'b0};
        txBusy  <= 1'b1;
        txTick  <= '0;
        txBitN  <= '0;
      end else if (txBusy && stb.tick) begin
        if (txTick == LAST_TICK) begin
          txTick  <= '0;
          txShift <= {1'b1, txShift[9:1]};
          if (txBitN == 4'(FRAME_BITS - 1)) txBusy <= 1'b0;
          else txBitN <= txBitN + 1'b1;
        end else txTick <= txTick + 1'b1;
      end
      txdOut <= stb.brk ? 1'b0 : (txBusy ? txShift[0] : 1'b1);
    end
  end

  assign evt.rxPushed   = rxPushReq;
  assign evt.rxOverrun  = rxPushReq && (rxCount == CW'(DEPTH));
  assign evt.rxFrameErr = rxPushReq && rxWord[8];
  assign evt.rxBreak    = rxPushReq && rxWord[9];
  assign evt.txPopped   = txLoad;
endmodule

// File: rtl/uart14_ctrl.sv
module uart14_ctrl
  import uart14_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int TW    = $clog2(16 * FRAME_BITS * BIT_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    busAddr,
  input  logic          busWrEn,
  input  logic          busRdEn,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  input  logic [CW-1:0] rxCount,
  input  logic [CW-1:0] txCount,
  input  logic [9:0]    rxHead,
  input  u14Event_t     evt,
  input  logic          ctsIn,
  output u14Strobe_t    stb,
  output logic          rtsOut,
  output logic          irqOut,
  output logic [21:0]   ctrlQ,
  output logic [5:0]    flagQ
);
  logic [7:0]  rateQ, divQ;
  logic [TW-1:0] tmoQ, tmoLimit;
  logic [7:0]  rxTrig, txTrig, rtsThr, rxLvl, txLvl;
  logic        tick, rxEmpty, tmoOn, tmoFire;
  logic [5:0]  flagSet, flagClr;
  logic        unusedW;

  assign unusedW = ^busWdata[31:22];
  assign rxLvl   = 8'(rxCount);
  assign txLvl   = 8'(txCount);
  assign rxEmpty = (rxCount == '0);
  assign tick    = (divQ == rateQ);

  always_comb begin
    case (ctrlQ[4:2])
      3'd0: rxTrig = 8'd1;   3'd1: rxTrig = 8'd4;
      3'd2: rxTrig = 8'd8;   3'd3: rxTrig = 8'd16;
      3'd4: rxTrig = 8'd32;  default: rxTrig = 8'd48;
    endcase
    case (ctrlQ[1:0])
      2'd0: txTrig = 8'd0;  2'd1: txTrig = 8'd4;
      2'd2: txTrig = 8'd8;  default: txTrig = 8'd16;
    endcase
    case (ctrlQ[20:19])
      2'd0: rtsThr = 8'd8;   2'd1: rtsThr = 8'd16;
      2'd2: rtsThr = 8'd32;  default: rtsThr = 8'd48;
    endcase
    case (ctrlQ[17:16])
      2'd1:    tmoLimit = TW'(4 * FRAME_BITS * BIT_TICKS);
      2'd2:    tmoLimit = TW'(8 * FRAME_BITS * BIT_TICKS);
      default: tmoLimit = TW'(16 * FRAME_BITS * BIT_TICKS);
    endcase
  end

  assign tmoOn   = (ctrlQ[17:16] != 2'd0) && !rxEmpty && !evt.rxPushed;
  assign tmoFire = tmoOn && tick && (tmoQ == tmoLimit - 1'b1);

  assign flagSet = {evt.rxOverrun, evt.rxBreak, evt.rxFrameErr, tmoFire,
                    !rxEmpty && (rxLvl >= rxTrig),
                    evt.txPopped && (txLvl - 8'd1 == txTrig)};
  assign flagClr = (busWrEn && busAddr == A_FLAGS) ? busWdata[5:0] : 6'd0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      rateQ <= '0;
      divQ  <= '0;
      tmoQ  <= '0;
      flagQ <= '0;
    end else begin
      divQ  <= tick ? 8'd0 : divQ + 1'b1;
      flagQ <= (flagQ & ~flagClr) | flagSet;
      if (!tmoOn) tmoQ <= '0;
      else if (tick && tmoQ != tmoLimit) tmoQ <= tmoQ + 1'b1;
      if (busWrEn && busAddr == A_CTRL) ctrlQ <= busWdata[21:0];
      if (busWrEn && busAddr == A_RATE) rateQ <= busWdata[7:0];
    end
  end

  always_comb begin
    case (busAddr)
      A_DATA:  busRdata = rxEmpty ? 32'h100 : {21'd0, rxHead[9:8], 1'b0, rxHead[7:0]};
      A_LEVEL: busRdata = {16'd0, txLvl, rxLvl};
      A_FLAGS: busRdata = {25'd0, txLvl <= txTrig, flagQ};
      A_CTRL:  busRdata = {10'd0, ctrlQ};
      A_RATE:  busRdata = {24'd0, rateQ};
      default: busRdata = 32'd0;
    endcase
  end

  assign stb.tick   = tick;
  assign stb.rxPop  = busRdEn && (busAddr == A_DATA);
  assign stb.txPush = busWrEn && (busAddr == A_DATA);
  assign stb.txByte = busWdata[7:0];
  assign stb.txGo   = !ctrlQ[14] || (ctsIn ^ ctrlQ[15]);
  assign stb.brk    = ctrlQ[8];

  assign rtsOut = (ctrlQ[18] ? (rxLvl < rtsThr) : 1'b1) ^ ctrlQ[21];
  assign irqOut = (flagQ[0] && ctrlQ[5]) || ((|flagQ[2:1]) && ctrlQ[6]) ||
                  ((|flagQ[5:3]) && ctrlQ[7]);
endmodule

// File: rtl/uart14_top.sv
module uart14_top
  import uart14_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        rxdIn,
  output logic        txdOut,
  input  logic        ctsIn,
  output logic        rtsOut,
  output logic        irqOut
);
  u14Strobe_t    stb;
  u14Event_t     evt;
  logic [CW-1:0] rxCount, txCount;
  logic [9:0]    rxHead;
  logic [21:0]   ctrlQ;
  logic [5:0]    flagQ;

  uart14_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWdata(busWdata), .busRdata(busRdata),
    .rxCount(rxCount), .txCount(txCount), .rxHead(rxHead), .evt(evt),
    .ctsIn(ctsIn), .stb(stb), .rtsOut(rtsOut), .irqOut(irqOut),
    .ctrlQ(ctrlQ), .flagQ(flagQ)
  );

  uart14_datapath #(.DEPTH(DEPTH)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .rxdIn(rxdIn), .txdOut(txdOut),
    .rxHead(rxHead), .rxCount(rxCount), .txCount(txCount), .evt(evt)
  );
endmodule

// File: rtl/uart14_chk.sv
module uart14_chk
  import uart14_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [21:0]   ctrlQ,
  input logic [5:0]    flagQ,
  input logic [CW-1:0] rxCount,
  input logic [CW-1:0] txCount,
  input logic          txdOut,
  input logic          ctsIn,
  input u14Event_t     evt
);
  // R6: neither queue count exceeds its depth
  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CW'(DEPTH) && txCount <= CW'(DEPTH));

  // R6: a dropped character only happens with a full receive queue
  a_r6_overrun_full: assert property (@(posedge clk) disable iff (!rstN)
    evt.rxOverrun |-> rxCount == CW'(DEPTH));

  // R13: forced break drives the line low on the next clock
  a_r13_break_low: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[8] |=> !txdOut);

  // R11: no frame starts while CTS gating holds transmission back
  a_r11_cts_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[14] && !(ctsIn ^ ctrlQ[15])) |-> !evt.txPopped);

  // R8: timeout flag only rises while characters are waiting
  a_r8_timeout_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[2]) |-> $past(rxCount) != '0);

  // R5: a break character is always also an error character
  a_r5_break_has_err: assert property (@(posedge clk) disable iff (!rstN)
    evt.rxBreak |-> evt.rxFrameErr);
endmodule

bind uart14_top uart14_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .flagQ(flagQ), .rxCount(rxCount),
  .txCount(txCount), .txdOut(txdOut), .ctsIn(ctsIn), .evt(evt)
);

// File: tb/tb_uart14_top.sv
`timescale 1ns/1ps
module tb_uart14_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic        rxdIn = 1'b1, txdOut, ctsIn = 1'b0, rtsOut, irqOut;
  int          checks = 0, fails = 0;

  always #10 clk = ~clk;

  uart14_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWdata(busWdata), .busRdata(busRdata),
    .rxdIn(rxdIn), .txdOut(txdOut), .ctsIn(ctsIn), .rtsOut(rtsOut), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; rxdIn = 1'b1; ctsIn = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b, input logic stopV);
    @(negedge clk);
    rxdIn = 1'b0;
    repeat (14) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxdIn = b[i];
      repeat (14) @(negedge clk);
    end
    rxdIn = stopV;
    repeat (14) @(negedge clk);
    rxdIn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic recvTx(input int bc, output logic [7:0] b, output logic stopV, output logic startV);
    int n = 0;
    @(negedge clk);
    while (txdOut && n < 3000) begin @(negedge clk); n++; end
    repeat (bc / 2) @(negedge clk);
    startV = txdOut;
    for (int i = 0; i < 8; i++) begin
      repeat (bc) @(negedge clk);
      b[i] = txdOut;
    end
    repeat (bc) @(negedge clk);
    stopV = txdOut;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    doReset();
    rd(3'd1, d); chk("R2 level after reset", d, 32'h0);
    rd(3'd2, d); chk("R7 flags after reset (bit6 live)", d, 32'h40);
    rd(3'd0, d); chk("R3 empty read", d, 32'h100);
    chk("R1 txd idle high", {31'd0, txdOut}, 32'd1);
  endtask

  task automatic t_txRate();
    logic [7:0] b; logic s, st;
    doReset();
    wr(3'd4, 32'd2);
    wr(3'd0, 32'h3C);
    recvTx(42, b, s, st);
    chk("R1 start bit low", {31'd0, st}, 32'd0);
    chk("R1 data LSB first at 42 clk/bit", {24'd0, b}, 32'h3C);
    chk("R1 stop bit high", {31'd0, s}, 32'd1);
  endtask

  task automatic t_rxBasic();
    logic [31:0] d;
    doReset();
    sendRx(8'hA5, 1'b1);
    sendRx(8'h5A, 1'b1);
    rd(3'd1, d); chk("R2 rx count in bits 7:0", d, 32'h2);
    rd(3'd0, d); chk("R3 first byte", d, 32'hA5);
    rd(3'd0, d); chk("R3 second byte", d, 32'h5A);
    rd(3'd1, d); chk("R3 reads removed entries", d, 32'h0);
    rd(3'd0, d); chk("R3 empty after drain", d, 32'h100);
  endtask

  task automatic t_glitch();
    logic [31:0] d;
    doReset();
    @(negedge clk); rxdIn = 1'b0;
    repeat (3) @(negedge clk); rxdIn = 1'b1;
    repeat (200) @(negedge clk);
    rd(3'd1, d); chk("R4 short low pulse ignored", d, 32'h0);
  endtask

  task automatic t_errors();
    logic [31:0] d;
    doReset();
    wr(3'd3, 32'h94);
    sendRx(8'h55, 1'b0);
    rd(3'd2, d); chk("R5 framing flag bit3", d & 32'h3F, 32'h08);
    chk("R10 error irq", {31'd0, irqOut}, 32'd1);
    rd(3'd0, d); chk("R5 error flag in word", d, 32'h255);
    sendRx(8'h00, 1'b0);
    rd(3'd2, d); chk("R5 break flag bit4", d & 32'h3F, 32'h18);
    rd(3'd0, d); chk("R5 break word", d, 32'h600);
    wr(3'd2, 32'h18);
    rd(3'd2, d); chk("R9 write-one clears", d & 32'h3F, 32'h0);
    chk("R10 irq drops", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic t_rxTrig();
    logic [31:0] d;
    doReset();
    wr(3'd3, 32'h4);
    for (int i = 0; i < 3; i++) sendRx(8'(i + 1), 1'b1);
    rd(3'd2, d); chk("R7 below rx trigger", d & 32'h2, 32'h0);
    sendRx(8'h44, 1'b1);
    rd(3'd2, d); chk("R7 at rx trigger", d & 32'h2, 32'h2);
  endtask

  task automatic t_txTrig();
    logic [31:0] d;
    doReset();
    wr(3'd0, 32'h81);
    repeat (5) @(negedge clk);
    rd(3'd2, d); chk("R7 tx flag bit0 and bit6", d, 32'h41);
    chk("R10 tx irq disabled", {31'd0, irqOut}, 32'd0);
    wr(3'd3, 32'h20);
    chk("R10 tx irq enabled", {31'd0, irqOut}, 32'd1);
    wr(3'd2, 32'h0);
    rd(3'd2, d); chk("R9 zero write keeps flag", d & 32'h1, 32'h1);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    doReset();
    wr(3'd3, 32'h14);
    for (int i = 0; i < 65; i++) sendRx(8'(i), 1'b1);
    rd(3'd1, d); chk("R6 queue holds 64", d, 32'h40);
    rd(3'd2, d); chk("R6 overrun flag bit5", d & 32'h20, 32'h20);
    rd(3'd0, d); chk("R6 oldest kept", d, 32'h0);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    doReset();
    wr(3'd3, 32'h10014);
    sendRx(8'h77, 1'b1);
    repeat (400) @(negedge clk);
    rd(3'd2, d); chk("R8 not yet expired", d & 32'h4, 32'h0);
    repeat (200) @(negedge clk);
    rd(3'd2, d); chk("R8 expired after 560 ticks", d & 32'h4, 32'h4);
    chk("R10 rx irq disabled", {31'd0, irqOut}, 32'd0);
    wr(3'd3, 32'h10054);
    chk("R10 rx irq enabled", {31'd0, irqOut}, 32'd1);
    wr(3'd2, 32'h4);
    repeat (700) @(negedge clk);
    rd(3'd2, d); chk("R8 fires once; R9 cleared", d & 32'h4, 32'h0);
  endtask

  task automatic t_cts();
    logic [31:0] d; logic [7:0] b; logic s, st; int lows = 0;
    doReset();
    wr(3'd3, 32'h4000);
    wr(3'd0, 32'h11); wr(3'd0, 32'h22); wr(3'd0, 32'h33);
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txdOut) lows++; end
    chk("R11 held by CTS", lows, 0);
    rd(3'd1, d); chk("R2 tx count in bits 15:8", d, 32'h0300);
    ctsIn = 1'b1;
    recvTx(14, b, s, st);
    chk("R11 sends after CTS", {24'd0, b}, 32'h11);
  endtask

  task automatic t_rts();
    doReset();
    wr(3'd3, 32'h40000);
    for (int i = 0; i < 7; i++) sendRx(8'(i), 1'b1);
    chk("R12 rts high below 8", {31'd0, rtsOut}, 32'd1);
    sendRx(8'h08, 1'b1);
    chk("R12 rts low at 8", {31'd0, rtsOut}, 32'd0);
    wr(3'd3, 32'h240000);
    chk("R12 rts inverted", {31'd0, rtsOut}, 32'd1);
  endtask

  task automatic t_break();
    logic [31:0] d;
    doReset();
    wr(3'd3, 32'h2900);
    @(negedge clk);
    chk("R13 break forces txd low", {31'd0, txdOut}, 32'd0);
    rd(3'd3, d); chk("R13 offset field readback", d, 32'h2900);
    wr(3'd3, 32'h0);
    repeat (2) @(negedge clk);
    chk("R13 txd released", {31'd0, txdOut}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_txRate();
    t_rxBasic();
    t_glitch();
    t_errors();
    t_rxTrig();
    t_txTrig();
    t_overrun();
    t_timeout();
    t_cts();
    t_rts();
    t_break();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule